// File: doc/BRIEF.md
# Hardwired Instruction-Cycle Control Unit

This block is the sequencing core of a small accumulator processor, built as fixed logic rather than from a control store. A two-bit cycle register says which phase of the instruction cycle is running: fetch, indirect, execute or interrupt. A one-hot timing counter marks the time steps T1, T2 and T3 inside that phase. A decoder turns the opcode into one line per opcode value. Each control output is a fixed sum of products over the cycle bits, the active time step and the decoded opcode lines.

The surrounding datapath holds the instruction register and drives `opcode_i`. It drives `ind_i` from the indirect-address bit of the fetched instruction and `irq_i` from the pending-interrupt flag. The datapath samples `ctl_o` once per clock. Every phase lasts three clocks. At its last step the counter returns to T1 and the cycle register takes the next phase. After reset the unit waits three clocks with every control output low. It then starts at fetch T1.

Top module: `hcu_top`

## Requirements
- R1: While `rst_ni` is low, and for the first three rising edges after it rises, `ctl_o` is all zero, `cycle_o` is 00 and `step_o` is 001. From the fourth edge on, the unit runs from fetch T1.
- R2: `cycle_o` reports the phase with this code: 00 fetch, 01 indirect, 10 execute, 11 interrupt.
- R3: `step_o` is one-hot, with bit 0 = T1, bit 1 = T2 and bit 2 = T3. While running it advances one bit per clock. After T3 it returns to T1.
- R4: At fetch T3, the phase that follows is indirect if `ind_i` is 1 and execute if it is 0.
- R5: At execute T3, the phase that follows is interrupt if `irq_i` is 1 and fetch if it is 0. Indirect is always followed by execute, and interrupt is always followed by fetch.
- R6: `ctl_o[1]` (read memory into the buffer register) is high at T2 of fetch and at T2 of indirect.
- R7: In execute, `ctl_o[1]` is high at T2 only when the opcode is 1 (load), 2 (add) or 3 (AND).
- R8: In fetch, `ctl_o[0]` (PC to address register) is high at T1, `ctl_o[2]` (PC increment) is high at T2 and `ctl_o[3]` (buffer to instruction register) is high at T3.
- R9: `ctl_o[4]` (operand address to address register) is high at indirect T1, and at execute T1 for opcodes 1 to 3. `ctl_o[6]` (accumulator load) is high at execute T3 for opcodes 1 to 3. `ctl_o[5]` (ALU enable) is high at execute T3 for opcodes 2 and 3.
- R10: `ctl_o[7]` (save PC) is high at interrupt T1. `ctl_o[8]` (load PC with the vector) is high at interrupt T2.
- R11: No bit of `ctl_o` is high at any step other than those listed above. In particular, every other opcode gives an all-zero execute phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| opcode_i | input | 4 | Opcode from the instruction register |
| ind_i | input | 1 | Indirect-address bit of the current instruction |
| irq_i | input | 1 | Pending interrupt request |
| ctl_o | output | 9 | Control-signal vector |
| cycle_o | output | 2 | Current phase code |
| step_o | output | 3 | One-hot time step |

## Verification
The bench builds the block with the default 4-bit opcode and three steps per phase. With those values all sixteen decoded lines can be driven within a few hundred clocks. The three memory-reading opcodes can be told apart from the other thirteen, which must give a silent execute phase. The bench drives every combination of indirect and interrupt paths, and applies a reset in the middle of a phase. This covers each of the four phase transitions and the startup hold.

// File: rtl/hcu_pkg.sv
package hcu_pkg;
  typedef enum logic [1:0] {
    CY_FETCH = 2'b00,
    CY_INDIR = 2'b01,
    CY_EXEC  = 2'b10,
    CY_INTR  = 2'b11
  } cycle_e;

  localparam int CTL_W = 9;

  localparam int C_PC2MAR  = 0;
  localparam int C_MEMRD   = 1;
  localparam int C_PCINC   = 2;
  localparam int C_IRLOAD  = 3;
  localparam int C_ADR2MAR = 4;
  localparam int C_ALUEN   = 5;
  localparam int C_ACCLD   = 6;
  localparam int C_PCSAVE  = 7;
  localparam int C_PCVEC   = 8;

  localparam int OP_LOAD = 1;
  localparam int OP_ADD  = 2;
  localparam int OP_AND  = 3;
endpackage

// File: rtl/hcu_rst_sync.sv
module hcu_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_no = sync_q[1];
endmodule

// File: rtl/hcu_timing.sv
module hcu_timing #(
  parameter int N_STEPS = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  output logic [N_STEPS-1:0] step_o,
  output logic               last_o
);
  localparam logic [N_STEPS-1:0] STEP_T1 = N_STEPS'(1);

  logic [N_STEPS-1:0] step_q, step_d;

  assign last_o = step_q[N_STEPS-1];

  always_comb begin
    step_d = step_q;
    if (en_i) begin
      if (last_o) step_d = STEP_T1;
      else        step_d = step_q << 1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) step_q <= STEP_T1;
    else         step_q <= step_d;
  end

  assign step_o = step_q;
endmodule

// File: rtl/hcu_cycle_fsm.sv
module hcu_cycle_fsm
  import hcu_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   en_i,
  input  logic   ind_i,
  input  logic   irq_i,
  output cycle_e cycle_o
);
  cycle_e cyc_q, cyc_d;

  always_comb begin
    cyc_d = cyc_q;
    if (en_i) begin
      unique case (cyc_q)
        CY_FETCH: cyc_d = ind_i ? CY_INDIR : CY_EXEC;
        CY_INDIR: cyc_d = CY_EXEC;
        CY_EXEC:  cyc_d = irq_i ? CY_INTR : CY_FETCH;
        CY_INTR:  cyc_d = CY_FETCH;
        default:  cyc_d = CY_FETCH;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cyc_q <= CY_FETCH;
    else         cyc_q <= cyc_d;
  end

  assign cycle_o = cyc_q;
endmodule

// File: rtl/hcu_opdec.sv
module hcu_opdec #(
  parameter int OPC_W = 4
) (
  input  logic [OPC_W-1:0]      opcode_i,
  output logic [2**OPC_W-1:0]   line_o
);
  localparam int N_LINES = 2**OPC_W;

  for (genvar i = 0; i < N_LINES; i++) begin : g_line
    assign line_o[i] = (opcode_i == OPC_W'(i));
  end
endmodule

// File: rtl/hcu_ctl_logic.sv
module hcu_ctl_logic
  import hcu_pkg::*;
#(
  parameter int OPC_W   = 4,
  parameter int N_STEPS = 3
) (
  input  logic                 run_i,
  input  logic [1:0]           cyc_i,
  input  logic [N_STEPS-1:0]   step_i,
  input  logic [2**OPC_W-1:0]  line_i,
  output logic [CTL_W-1:0]     ctl_o
);
  logic p, q, fe, ind, ex, itr, t1, t2, t3, mem_op, alu_op;
  logic [CTL_W-1:0] raw;

  assign p   = cyc_i[1];
  assign q   = cyc_i[0];
  assign fe  = ~p & ~q;
  assign ind = ~p &  q;
  assign ex  =  p & ~q;
  assign itr =  p &  q;
  assign t1  = step_i[0];
  assign t2  = step_i[1];
  assign t3  = step_i[2];

  assign mem_op = line_i[OP_LOAD] | line_i[OP_ADD] | line_i[OP_AND];
  assign alu_op = line_i[OP_ADD] | line_i[OP_AND];

  always_comb begin
    raw            = '0;
    raw[C_PC2MAR]  = fe & t1;
    raw[C_MEMRD]   = (fe & t2) | (ind & t2) | (ex & t2 & mem_op);
    raw[C_PCINC]   = fe & t2;
    raw[C_IRLOAD]  = fe & t3;
    raw[C_ADR2MAR] = (ind & t1) | (ex & t1 & mem_op);
    raw[C_ALUEN]   = ex & t3 & alu_op;
    raw[C_ACCLD]   = ex & t3 & mem_op;
    raw[C_PCSAVE]  = itr & t1;
    raw[C_PCVEC]   = itr & t2;
  end

  assign ctl_o = run_i ? raw : '0;
endmodule

// File: rtl/hcu_top.sv
module hcu_top
  import hcu_pkg::*;
#(
  parameter int OPC_W   = 4,
  parameter int N_STEPS = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [OPC_W-1:0]    opcode_i,
  input  logic                ind_i,
  input  logic                irq_i,
  output logic [CTL_W-1:0]    ctl_o,
  output logic [1:0]          cycle_o,
  output logic [N_STEPS-1:0]  step_o
);
  localparam int N_LINES = 2**OPC_W;

  logic               rst_sync_n;
  logic               run_q;
  logic               last_step;
  logic               adv;
  logic [N_LINES-1:0] op_line;
  cycle_e             cyc;

  hcu_rst_sync u_rst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_sync_n)
  );

  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n) run_q <= 1'b0;
    else             run_q <= 1'b1;
  end

  assign adv = run_q & last_step;

  hcu_timing #(.N_STEPS(N_STEPS)) u_tim (
    .clk_i  (clk_i),
    .rst_ni (rst_sync_n),
    .en_i   (run_q),
    .step_o (step_o),
    .last_o (last_step)
  );

  hcu_cycle_fsm u_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_sync_n),
    .en_i    (adv),
    .ind_i   (ind_i),
    .irq_i   (irq_i),
    .cycle_o (cyc)
  );

  hcu_opdec #(.OPC_W(OPC_W)) u_dec (
    .opcode_i (opcode_i),
    .line_o   (op_line)
  );

  hcu_ctl_logic #(.OPC_W(OPC_W), .N_STEPS(N_STEPS)) u_ctl (
    .run_i  (run_q),
    .cyc_i  (cyc),
    .step_i (step_o),
    .line_i (op_line),
    .ctl_o  (ctl_o)
  );

  assign cycle_o = cyc;
endmodule

// File: rtl/hcu_chk.sv
module hcu_chk
  import hcu_pkg::*;
#(
  parameter int OPC_W   = 4,
  parameter int N_STEPS = 3
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               run_q,
  input logic [OPC_W-1:0]   opcode_i,
  input logic               ind_i,
  input logic               irq_i,
  input logic [CTL_W-1:0]   ctl_o,
  input logic [1:0]         cycle_o,
  input logic [N_STEPS-1:0] step_o
);
  localparam logic [N_STEPS-1:0] STEP_T1 = N_STEPS'(1);

  logic rd_op;
  assign rd_op = (opcode_i == OPC_W'(OP_LOAD)) || (opcode_i == OPC_W'(OP_ADD)) ||
                 (opcode_i == OPC_W'(OP_AND));

  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_q |-> (ctl_o == '0));

  p_step_onehot_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(step_o) == 1);

  p_step_shift_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && !step_o[N_STEPS-1]) |=> (step_o == ($past(step_o) << 1)));

  p_step_wrap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && step_o[N_STEPS-1]) |=> (step_o == STEP_T1));

  p_fetch_next_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && cycle_o == CY_FETCH && step_o[N_STEPS-1])
      |=> (cycle_o == ($past(ind_i) ? CY_INDIR : CY_EXEC)));

  p_exec_next_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && cycle_o == CY_EXEC && step_o[N_STEPS-1])
      |=> (cycle_o == ($past(irq_i) ? CY_INTR : CY_FETCH)));

  p_indir_next_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && cycle_o == CY_INDIR && step_o[N_STEPS-1]) |=> (cycle_o == CY_EXEC));

  p_memrd_fetch_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && cycle_o != CY_EXEC && !cycle_o[1] && step_o[1]) |-> ctl_o[C_MEMRD]);

  p_memrd_exec_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && cycle_o == CY_EXEC && step_o[1]) |-> (ctl_o[C_MEMRD] == rd_op));

  p_pc2mar_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && cycle_o == CY_FETCH && step_o[0]) |-> ctl_o[C_PC2MAR]);

  p_intr_save_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && cycle_o == CY_INTR && step_o[0]) |-> ctl_o[C_PCSAVE]);
endmodule

bind hcu_top hcu_chk #(.OPC_W(OPC_W), .N_STEPS(N_STEPS)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .run_q    (run_q),
  .opcode_i (opcode_i),
  .ind_i    (ind_i),
  .irq_i    (irq_i),
  .ctl_o    (ctl_o),
  .cycle_o  (cycle_o),
  .step_o   (step_o)
);

// File: tb/tb_hcu_top.sv
module tb_hcu_top;
  logic       clk_i;
  logic       rst_ni;
  logic [3:0] opcode_i;
  logic       ind_i;
  logic       irq_i;
  logic [8:0] ctl_o;
  logic [1:0] cycle_o;
  logic [2:0] step_o;

  int n_tests;
  int n_fail;
  bit done;

  int m_sync;
  int m_run;
  int m_cyc;
  int m_step;

  hcu_top dut (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .opcode_i (opcode_i),
    .ind_i    (ind_i),
    .irq_i    (irq_i),
    .ctl_o    (ctl_o),
    .cycle_o  (cycle_o),
    .step_o   (step_o)
  );

  initial clk_i = 1'b0;
  always #10 clk_i = ~clk_i;

  function automatic logic [8:0] exp_ctl(int run, int cyc, int stp, int op);
    logic [8:0] v;
    bit rd;
    v  = '0;
    rd = (op == 1) || (op == 2) || (op == 3);
    if (run == 0) return v;
    case (cyc)
      0: begin
        if (stp == 0) v[0] = 1'b1;
        if (stp == 1) begin v[1] = 1'b1; v[2] = 1'b1; end
        if (stp == 2) v[3] = 1'b1;
      end
      1: begin
        if (stp == 0) v[4] = 1'b1;
        if (stp == 1) v[1] = 1'b1;
      end
      2: begin
        if (rd && stp == 0) v[4] = 1'b1;
        if (rd && stp == 1) v[1] = 1'b1;
        if (rd && stp == 2) begin
          v[6] = 1'b1;
          if (op != 1) v[5] = 1'b1;
        end
      end
      default: begin
        if (stp == 0) v[7] = 1'b1;
        if (stp == 1) v[8] = 1'b1;
      end
    endcase
    return v;
  endfunction

  function automatic string bit_tag(int b, int cyc);
    if (b == 1) return (cyc == 2) ? "R7" : "R6";
    if (b == 0 || b == 2 || b == 3) return "R8";
    if (b >= 4 && b <= 6) return "R9";
    return "R10";
  endfunction

  task automatic compare();
    logic [8:0] e;
    e = exp_ctl(m_run, m_cyc, m_step, int'(opcode_i));
    n_tests++;
    if (ctl_o != e) begin
      n_fail++;
      for (int b = 0; b < 9; b++) begin
        if (ctl_o[b] != e[b]) begin
          if (m_run == 0)
            $display("FAIL R1 ctl_o bit %0d: actual %b expected %b (ctl %b vs %b)", b, ctl_o[b], e[b], ctl_o, e);
          else if (e[b] == 1'b0)
            $display("FAIL R11 ctl_o bit %0d spurious (also %s): actual %b expected %b", b, bit_tag(b, m_cyc), ctl_o, e);
          else
            $display("FAIL %s ctl_o bit %0d: actual %b expected %b", bit_tag(b, m_cyc), b, ctl_o, e);
        end
      end
    end
    n_tests++;
    if (cycle_o != 2'(m_cyc)) begin
      n_fail++;
      $display("FAIL R2 cycle_o: actual %b expected %b", cycle_o, 2'(m_cyc));
    end
    n_tests++;
    if (step_o != 3'(1 << m_step)) begin
      n_fail++;
      $display("FAIL R3 step_o: actual %b expected %b", step_o, 3'(1 << m_step));
    end
  endtask

  task automatic model_edge();
    if (rst_ni == 1'b0) return;
    if (m_sync < 2) m_sync++;
    else if (m_run == 0) m_run = 1;
    else if (m_step == 2) begin
      m_step = 0;
      case (m_cyc)
        0: m_cyc = ind_i ? 1 : 2;
        1: m_cyc = 2;
        2: m_cyc = irq_i ? 3 : 0;
        default: m_cyc = 0;
      endcase
    end else m_step++;
  endtask

  task automatic model_reset();
    m_sync = 0; m_run = 0; m_cyc = 0; m_step = 0;
  endtask

  task automatic tick(input logic [3:0] op, input logic ind, input logic irq, input logic rst);
    @(negedge clk_i);
    compare();
    opcode_i = op;
    ind_i    = ind;
    irq_i    = irq;
    rst_ni   = rst;
    if (!rst) model_reset();
    @(posedge clk_i);
    model_edge();
  endtask

  initial begin
    n_tests = 0; n_fail = 0; done = 0;
    rst_ni = 1'b0; opcode_i = '0; ind_i = 1'b0; irq_i = 1'b0;
    model_reset();
    // R1: held reset, then three startup edges
    for (int i = 0; i < 4; i++) tick(4'd1, 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 4; i++) tick(4'd1, 1'b0, 1'b0, 1'b1);
    // R4, R5, R6..R8: direct instruction, no interrupt
    for (int i = 0; i < 12; i++) tick(4'd1, 1'b0, 1'b0, 1'b1);
    // R4 indirect path, R9 indirect T1
    for (int i = 0; i < 12; i++) tick(4'd2, 1'b1, 1'b0, 1'b1);
    // R5 interrupt path, R10
    for (int i = 0; i < 12; i++) tick(4'd3, 1'b0, 1'b1, 1'b1);
    // R7, R9, R11: every opcode, varied indirect and interrupt
    for (int op = 0; op < 16; op++)
      for (int i = 0; i < 12; i++)
        tick(4'(op), op[0], (op % 3) == 0, 1'b1);
    // R1: reset in the middle of a phase
    for (int i = 0; i < 4; i++) tick(4'd2, 1'b1, 1'b1, 1'b1);
    for (int i = 0; i < 2; i++) tick(4'd2, 1'b1, 1'b1, 1'b0);
    for (int i = 0; i < 15; i++) tick(4'd3, 1'b1, 1'b1, 1'b1);
    @(negedge clk_i);
    compare();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule